// File: doc/BRIEF.md
# Two-wire bus event decoder with queued SDA responder

The block listens to an open-drain two-wire serial bus whose clock (SCL) and data (SDA) lines arrive already synchronized to the system clock. It turns what it sees into a single stream of events: start condition, stop condition, each received 8-bit data word, and the acknowledge slot that follows it. Each event is one clock of `evt_valid_o`, with a 3-bit kind code and the data value.

The block can also take part in the traffic. Software or a neighbouring block loads single bits into a small FIFO. Each time SCL falls, the block waits a programmable number of system clocks, roughly a quarter of a bit period. It then dequeues one bit and applies it to SDA through an open-drain pull-down enable. A 0 pulls the line low and a 1 leaves it released. When the FIFO is empty the line is released. The `sda_i` the block observes is the wired-AND of every agent on the bus, its own pull-down included. This lets a responder return acknowledges or read data without any address or register logic.

Top module: `i2c_evt_responder`

## Requirements
- R1: A falling SDA while SCL is high in both this and the previous sample is a start. It produces one event of kind 0, clears the bit counter and clears the partial word.
- R2: A rising SDA while SCL is high in both samples is a stop. It produces one event of kind 1, releases the pull-down (`sda_oe_o` = 0) and cancels any pending drive, so no FIFO bit is consumed.
- R3: Each rising SCL samples SDA into the word most significant bit first and advances the bit counter.
- R4: The eighth rising SCL after a start or an acknowledge slot produces an event of kind 2, whose `evt_data_o` holds the eight sampled bits (first sampled in bit 7).
- R5: The ninth rising SCL produces kind 3 (acknowledge) if SDA is low and kind 4 (not-acknowledge) if it is high. Counting then restarts at zero.
- R6: Let edge 1 be the first rising clock edge that samples SCL low after it was high. `sda_oe_o` takes its new value after edge QTR_DLY+1. It becomes 1 when the dequeued bit is 0 and 0 when the bit is 1, and exactly one FIFO bit is consumed.
- R7: If the FIFO is empty when the drive delay expires, `sda_oe_o` becomes 0 and nothing is consumed.
- R8: An SCL fall that arrives while a drive delay is pending restarts the delay, and only one bit is consumed for the two falls.
- R9: The FIFO holds FIFO_DEPTH bits (default 16) and returns them in push order. `empty_o` is 1 with zero entries and `full_o` is 1 with FIFO_DEPTH entries.
- R10: A push while full stores nothing, and `overflow_o` is 1 for exactly the one clock after that push.
- R11: `evt_valid_o` is high for one clock per bus condition. It appears on the clock after the edge that samples the condition, and kind codes above 4 never appear.
- R12: A start that arrives partway through a word discards the partial bits, so the next word is assembled from eight fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level (wired-AND of all agents) |
| push_i | input | 1 | Load one drive bit into the FIFO |
| push_bit_i | input | 1 | Bit to load: 0 pulls SDA low, 1 releases it |
| full_o | output | 1 | FIFO holds FIFO_DEPTH bits |
| empty_o | output | 1 | FIFO holds no bits |
| overflow_o | output | 1 | One-clock pulse after a push rejected while full |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| evt_valid_o | output | 1 | One-clock event strobe |
| evt_kind_o | output | 3 | 0 start, 1 stop, 2 data, 3 acknowledge, 4 not-acknowledge |
| evt_data_o | output | DATA_W | Received word for kind 2 |

## Verification
The assertions assume that SCL and SDA never change in the same system clock. They also assume SDA changes only while SCL is low, except for deliberate start and stop conditions, and that each bus phase lasts longer than QTR_DLY+1 clocks. Under these assumptions a rise of SCL can never coincide with a start or stop. The bench drives the bus from tasks that move one line per step and hold each phase for 16 clocks with the default delay of 8. The only shortened phases are the directed cases that probe delay restart and stop cancellation. Random transactions push no more drive bits than the data and acknowledge slots will consume, so the line is released before every stop.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  typedef enum logic [2:0] {
    EVT_START = 3'd0,
    EVT_STOP  = 3'd1,
    EVT_DATA  = 3'd2,
    EVT_ACK   = 3'd3,
    EVT_NACK  = 3'd4
  } evt_kind_e;

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_i;
    sda_d = sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_frame_decoder.sv
module i2c_frame_decoder
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              evt_valid_o,
  output evt_kind_e         evt_kind_o,
  output logic [DATA_W-1:0] evt_data_o
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_SLOT = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  bit_cnt, bit_cnt_n, cnt_inc;
  logic [DATA_W-1:0] shreg, shreg_n;
  logic              vld_n;
  evt_kind_e         kind_n;
  logic [DATA_W-1:0] data_n;

  assign cnt_inc = bit_cnt + CNT_ONE;

  always_comb begin
    bit_cnt_n = bit_cnt;
    shreg_n   = shreg;
    vld_n     = 1'b0;
    kind_n    = evt_kind_o;
    data_n    = evt_data_o;
    if (start_i) begin
      bit_cnt_n = '0;
      shreg_n   = '0;
      vld_n     = 1'b1;
      kind_n    = EVT_START;
    end else if (stop_i) begin
      vld_n  = 1'b1;
      kind_n = EVT_STOP;
    end else if (scl_rise_i) begin
      bit_cnt_n = cnt_inc;
      shreg_n   = {shreg[DATA_W-2:0], sda_i};
      if (cnt_inc == CNT_WORD) begin
        vld_n  = 1'b1;
        kind_n = EVT_DATA;
        data_n = shreg_n;
      end else if (cnt_inc == CNT_SLOT) begin
        vld_n     = 1'b1;
        kind_n    = sda_i ? EVT_NACK : EVT_ACK;
        bit_cnt_n = '0;
        shreg_n   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      evt_valid_o <= 1'b0;
      evt_kind_o  <= EVT_START;
      evt_data_o  <= '0;
    end else begin
      bit_cnt     <= bit_cnt_n;
      shreg       <= shreg_n;
      evt_valid_o <= vld_n;
      evt_kind_o  <= kind_n;
      evt_data_o  <= data_n;
    end
  end

  // R1
  start_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> evt_valid_o && evt_kind_o == EVT_START && bit_cnt == '0);

  // R4
  word_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise_i && bit_cnt == CNT_PRE) |=>
      evt_valid_o && evt_kind_o == EVT_DATA && evt_data_o[0] == $past(sda_i));

  // R5
  slot_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise_i && bit_cnt == CNT_WORD) |=>
      evt_valid_o && bit_cnt == '0 &&
      evt_kind_o == ($past(sda_i) ? EVT_NACK : EVT_ACK));

  // R11
  kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> evt_kind_o <= EVT_NACK);

endmodule

// File: rtl/drv_bit_fifo.sv
module drv_bit_fifo #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic din_i,
  input  logic pop_i,
  output logic dout_o,
  output logic full_o,
  output logic empty_o,
  output logic overflow_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [DEPTH-1:0] mem;
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CNT_W-1:0] count, count_n;
  logic             wr_en, rd_en, ovf_n;

  assign full_o  = (count == CNT_FULL);
  assign empty_o = (count == '0);
  assign dout_o  = mem[rd_ptr];

  always_comb begin
    wr_en    = push_i & ~full_o;
    rd_en    = pop_i & ~empty_o;
    ovf_n    = push_i & full_o;
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (wr_en) wr_ptr_n = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_ONE;
    if (rd_en) rd_ptr_n = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_ONE;
    case ({wr_en, rd_en})
      2'b10:   count_n = count + CNT_ONE;
      2'b01:   count_n = count - CNT_ONE;
      default: count_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      overflow_o <= 1'b0;
    end else begin
      wr_ptr     <= wr_ptr_n;
      rd_ptr     <= rd_ptr_n;
      count      <= count_n;
      overflow_o <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din_i;
  end

  // R10
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> overflow_o);

  // R10
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> full_o && $stable(wr_ptr));

  // R9
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> !full_o && count == $past(count) - CNT_ONE);

endmodule

// File: rtl/drv_phase_timer.sv
module drv_phase_timer #(
  parameter int QTR_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall_i,
  input  logic cancel_i,
  output logic fire_o
);

  localparam int DLY_W = $clog2(QTR_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(QTR_DLY);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic [DLY_W-1:0] remain, remain_n;

  always_comb begin
    remain_n = remain;
    if (cancel_i)             remain_n = '0;
    else if (scl_fall_i)      remain_n = DLY_LOAD;
    else if (remain != '0)    remain_n = remain - DLY_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else        remain <= remain_n;
  end

  assign fire_o = (remain == DLY_ONE) & ~scl_fall_i & ~cancel_i;

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_i && !cancel_i) |=> !fire_o || DLY_LOAD == DLY_ONE);

endmodule

// File: rtl/i2c_evt_responder.sv
module i2c_evt_responder
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int QTR_DLY    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              push_i,
  input  logic              push_bit_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic              sda_oe_o,
  output logic              evt_valid_o,
  output logic [2:0]        evt_kind_o,
  output logic [DATA_W-1:0] evt_data_o
);

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  logic fire, fifo_dout, fifo_pop;
  logic oe_n;
  evt_kind_e dec_kind;

  i2c_line_watch u_watch (
    .clk        (clk),
    .rst_n      (rst_sn),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_frame_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_sn),
    .scl_rise_i  (scl_rise),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_i       (sda_i),
    .evt_valid_o (evt_valid_o),
    .evt_kind_o  (dec_kind),
    .evt_data_o  (evt_data_o)
  );
  assign evt_kind_o = dec_kind;

  drv_bit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sn),
    .push_i     (push_i),
    .din_i      (push_bit_i),
    .pop_i      (fifo_pop),
    .dout_o     (fifo_dout),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .overflow_o (overflow_o)
  );

  drv_phase_timer #(.QTR_DLY(QTR_DLY)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sn),
    .scl_fall_i (scl_fall),
    .cancel_i   (stop_det),
    .fire_o     (fire)
  );

  always_comb begin
    oe_n     = sda_oe_o;
    fifo_pop = 1'b0;
    if (stop_det) begin
      oe_n = 1'b0;
    end else if (fire) begin
      if (!empty_o) begin
        oe_n     = ~fifo_dout;
        fifo_pop = 1'b1;
      end else begin
        oe_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sda_oe_o <= 1'b0;
    else         sda_oe_o <= oe_n;
  end

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_det |=> !sda_oe_o);

  // R6
  drive_bit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (fire && !empty_o && !stop_det) |=> sda_oe_o == !$past(fifo_dout));

  // R7
  empty_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (fire && empty_o && !stop_det) |=> !sda_oe_o && $stable(empty_o));

endmodule

// File: tb/tb_i2c_evt_responder.sv
`timescale 1ns/1ps
module tb_i2c_evt_responder;

  localparam int DLY = 8;
  localparam int H   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic push_i, push_bit_i;
  logic full_o, empty_o, overflow_o, sda_oe_o, evt_valid_o;
  logic [2:0] evt_kind_o;
  logic [7:0] evt_data_o;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe_o;

  i2c_evt_responder #(.DATA_W(8), .FIFO_DEPTH(16), .QTR_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .push_i(push_i), .push_bit_i(push_bit_i),
    .full_o(full_o), .empty_o(empty_o), .overflow_o(overflow_o),
    .sda_oe_o(sda_oe_o), .evt_valid_o(evt_valid_o),
    .evt_kind_o(evt_kind_o), .evt_data_o(evt_data_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // drive queue model
  bit qm [0:15];
  int qh = 0, qt = 0, qcnt = 0;
  bit last_drv;
  logic cur_oe = 1'b0;

  // event records
  int   n_act = 0, n_exp = 0;
  logic [2:0] act_k [0:63];
  logic [7:0] act_d [0:63];
  logic [2:0] exp_k [0:63];
  logic [7:0] exp_d [0:63];
  bit   prev_v = 1'b0;
  bit   mon_on = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && evt_valid_o) begin
      if (n_act < 64) begin
        act_k[n_act] = evt_kind_o;
        act_d[n_act] = evt_data_o;
      end
      n_act++;
      checks++;
      if (prev_v) begin
        fails++;
        $display("FAIL R11 strobe longer than one clock actual=1 expected=0");
      end
    end
    prev_v = evt_valid_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_bit(input bit b);
    push_i = 1'b1; push_bit_i = b;
    tick(1);
    push_i = 1'b0;
    if (qcnt < 16) begin qm[qt] = b; qt = (qt + 1) % 16; qcnt++; end
  endtask

  task automatic add_exp(input logic [2:0] k, input logic [7:0] d);
    exp_k[n_exp] = k; exp_d[n_exp] = d; n_exp++;
  endtask

  task automatic clear_ev();
    n_act = 0; n_exp = 0;
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare_ev();
    tick(4);
    chk("R11 event count", n_act, n_exp);
    for (int i = 0; i < n_exp && i < n_act; i++) begin
      chk(tag_of(exp_k[i]), act_k[i], exp_k[i]);
      if (exp_k[i] == 3'd2) chk("R3 word", act_d[i], exp_d[i]);
    end
  endtask

  // SCL low phase with drive timing checks (R6/R7)
  task automatic low_phase();
    bit drv, from_q;
    logic exp_oe;
    scl_m = 1'b0;
    from_q = (qcnt > 0);
    if (from_q) begin drv = qm[qh]; qh = (qh + 1) % 16; qcnt--; end
    else drv = 1'b1;
    exp_oe = ~drv;
    tick(DLY);
    chk("R6 before delay", sda_oe_o, cur_oe);
    tick(1);
    chk(from_q ? "R6 drive" : "R7 release", sda_oe_o, exp_oe);
    cur_oe = exp_oe;
    last_drv = drv;
    tick(H - DLY - 1);
  endtask

  task automatic send_bit(input bit mb, output bit line);
    low_phase();
    sda_m = mb;
    tick(H);
    scl_m = 1'b1;
    tick(H);
    line = mb & last_drv;
  endtask

  task automatic send_word(input logic [7:0] mb, input bit ack);
    logic [7:0] got;
    bit l;
    for (int i = 7; i >= 0; i--) begin
      send_bit(mb[i], l);
      got[i] = l;
    end
    add_exp(3'd2, got);
    send_bit(ack, l);
    add_exp(l ? 3'd4 : 3'd3, 8'h00);
  endtask

  task automatic start_cond();
    sda_m = 1'b0;
    tick(H);
    add_exp(3'd0, 8'h00);
  endtask

  task automatic restart_cond();
    low_phase();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    add_exp(3'd0, 8'h00);
  endtask

  task automatic stop_cond();
    low_phase();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
    add_exp(3'd1, 8'h00);
  endtask

  initial begin
    int unused_seed;
    bit l;
    unused_seed = $urandom(32'h1c2b_0d5e);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; push_i = 1'b0; push_bit_i = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    mon_on = 1'b1;

    // reset state
    chk("R9 empty at reset", empty_o, 1'b1);
    chk("R9 full at reset", full_o, 1'b0);
    chk("R10 overflow at reset", overflow_o, 1'b0);
    chk("R7 released at reset", sda_oe_o, 1'b0);
    chk("R11 no event at reset", evt_valid_o, 1'b0);

    // R3 R4 R5: plain listening, ack and nack
    clear_ev();
    start_cond();
    send_word(8'hA5, 1'b0);
    send_word(8'h3C, 1'b1);
    stop_cond();
    compare_ev();

    // R6: responder drives word 0x96 then an ack
    for (int i = 7; i >= 0; i--) push_bit(((8'h96 >> i) & 1) != 0);
    push_bit(1'b0);
    clear_ev();
    start_cond();
    send_word(8'hFF, 1'b1);
    stop_cond();
    compare_ev();
    chk("R6 responder word", (n_act > 1) ? act_d[1] : 8'hxx, 8'h96);
    chk("R6 responder ack", (n_act > 2) ? act_k[2] : 3'hx, 3'd3);

    // R12: start in the middle of a word
    clear_ev();
    start_cond();
    send_bit(1'b0, l); send_bit(1'b1, l); send_bit(1'b0, l);
    restart_cond();
    send_word(8'h5E, 1'b0);
    stop_cond();
    compare_ev();
    chk("R12 word after restart", (n_act > 2) ? act_d[2] : 8'hxx, 8'h5E);

    // R9 R10: fill, overflow, ordered drain
    for (int i = 0; i < 16; i++) begin
      push_bit(i[0]);
      if (i == 14) chk("R9 not full at 15", full_o, 1'b0);
    end
    chk("R9 full at 16", full_o, 1'b1);
    chk("R9 not empty", empty_o, 1'b0);
    push_i = 1'b1; push_bit_i = 1'b0;
    tick(1);
    push_i = 1'b0;
    chk("R10 overflow pulse", overflow_o, 1'b1);
    chk("R10 still full", full_o, 1'b1);
    tick(1);
    chk("R10 overflow one clock", overflow_o, 1'b0);
    for (int i = 0; i < 17; i++) send_bit(1'b1, l);
    chk("R9 empty after drain", empty_o, 1'b1);

    // R2: stop cancels a pending drive
    push_bit(1'b0);
    clear_ev();
    scl_m = 1'b0; tick(1);
    sda_m = 1'b0; tick(1);
    scl_m = 1'b1; tick(1);
    sda_m = 1'b1; tick(DLY + 4);
    chk("R2 no drive after stop", sda_oe_o, 1'b0);
    chk("R2 stop reported", (n_act > 0) ? act_k[0] : 3'hx, 3'd1);
    chk("R2 bit kept", empty_o, 1'b0);

    // R8: second fall restarts the delay; queued 0 used once
    scl_m = 1'b0; tick(3);
    scl_m = 1'b1; tick(1);
    scl_m = 1'b0;
    qh = (qh + 1) % 16; qcnt--;
    tick(DLY);
    chk("R8 held until restarted delay", sda_oe_o, 1'b0);
    tick(1);
    chk("R8 drive after restarted delay", sda_oe_o, 1'b1);
    chk("R8 one bit consumed", empty_o, 1'b1);
    cur_oe = 1'b1;
    tick(H);
    scl_m = 1'b1; tick(H);
    low_phase();
    scl_m = 1'b1; tick(H);

    // random transactions
    for (int t = 0; t < 25; t++) begin
      int nw, np;
      nw = $urandom_range(1, 3);
      np = $urandom_range(0, 9 * nw);
      if (np > 16) np = 16;
      for (int i = 0; i < np; i++) push_bit($urandom_range(0, 1) != 0);
      clear_ev();
      start_cond();
      for (int w = 0; w < nw; w++) send_word(8'($urandom_range(0, 255)), $urandom_range(0, 1) != 0);
      stop_cond();
      compare_ev();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule